// File: doc/BRIEF.md
# Exception and Interrupt Entry Controller

This block handles the single-cycle entry into a trap handler for a 32-bit soft processor. Each cycle it looks at four request lines: MMU fault, hardware break, software break and external interrupt. It also sees the current program counter, the machine status word, the delay-slot and immediate-prefix flags, and the branch target that is pending. If it accepts a request, then one clock later it raises, for exactly one cycle, the strobes that do the following:

- write a link register in the register file;
- load a new status word;
- redirect the program counter;
- where needed, mark the exception status word and load the branch-target register.

A fault in the middle of a branch/delay-slot pair, or one that comes just after an immediate prefix, must restart the whole group. For this reason the saved return address is moved back by one or two instruction words. On every entry the virtual-mode and user-mode bits are saved into their shadow positions, and then both are cleared. The owner of the request lines drops a request once its strobes are seen. A request that is refused changes nothing and can simply stay raised.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every strobe output (rf_we, msr_we, pc_we, esr_ds_set, btr_we, flags_clr) is low.
- R2: An accepted MMU fault writes register 17 with the return address. It loads the PC with 0x20, sets bit 9 (exception in progress) of the new status word, and pulses flags_clr.
- R3: An MMU fault taken with dslot_in high pulses esr_ds_set (set bit 12 of the exception status word). It also loads btr_out with btgt_in, and saves pc_in minus 4.
- R4: An MMU fault with dslot_in and bimm_in both high saves pc_in minus 8.
- R5: An MMU fault with dslot_in low and imm_in high saves pc_in minus 4, and does not pulse esr_ds_set or btr_we. With both flags low, it saves pc_in unchanged.
- R6: On every accepted entry, the new status word has bit 14 equal to the old bit 13 and bit 12 equal to the old bit 11. Bits 13 and 11 are cleared. All other bits keep their values unless another requirement changes them.
- R7: An interrupt is accepted only when status bit 1 (enable) is set, bits 9 and 3 are clear, and dslot_in is low. A refused interrupt produces no strobe.
- R8: An accepted interrupt writes register 14 with pc_in, clears status bit 1, and loads the PC with 0x10.
- R9: A hardware break writes register 16 with pc_in, sets status bit 3 (break in progress), and loads the PC with 0x18.
- R10: A software break sets status bit 3 and loads the PC with btgt_in, without writing the register file.
- R11: When requests arrive together, the MMU fault wins over the hardware break, which wins over the software break, which wins over the interrupt.
- R12: All outputs of an entry appear in the cycle after the request is sampled. The strobes last one cycle when the request is then withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_mmu | input | 1 | MMU fault pending |
| req_hwbrk | input | 1 | Hardware break pending |
| req_swbrk | input | 1 | Software break pending |
| req_irq | input | 1 | External interrupt pending |
| pc_in | input | 32 | Current program counter |
| msr_in | input | 32 | Current machine status word |
| dslot_in | input | 1 | Current instruction is in a delay slot |
| imm_in | input | 1 | Current instruction follows an immediate prefix |
| btgt_in | input | 32 | Pending branch target |
| bimm_in | input | 1 | Pending branch carried an immediate prefix |
| rf_we | output | 1 | Register file write strobe |
| rf_idx | output | 5 | Register file write index |
| rf_data | output | 32 | Register file write data (link address) |
| msr_we | output | 1 | Status word load strobe |
| msr_out | output | 32 | New status word |
| pc_we | output | 1 | PC redirect strobe |
| pc_out | output | 32 | Handler address |
| esr_ds_set | output | 1 | Set the delay-slot bit of the exception status word |
| btr_we | output | 1 | Branch-target register load strobe |
| btr_out | output | 32 | Value for the branch-target register |
| flags_clr | output | 1 | Clear the delay-slot and immediate-prefix flags |

## Verification
The bound assertions check the following on every cycle:

- the fixed handler vectors and link indices;
- the interrupt gate against the status word and delay slot;
- the mode-bit save;
- the absence of a register write on a software break;
- that the register write and status load never occur without a PC redirect.

The amount of return-address rewind for each flag combination, and the full priority order among simultaneous requests, are shown only by the bench's scenarios. The same holds for the exact status words produced from mixed mode-bit patterns, which the bench compares against an independently built expectation.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  parameter int INSN_BYTES = 4,
  parameter logic [XLEN-1:0] VEC_MMU = 'h20,
  parameter logic [XLEN-1:0] VEC_IRQ = 'h10,
  parameter logic [XLEN-1:0] VEC_HWBRK = 'h18,
  parameter int LINK_MMU = 17,
  parameter int LINK_IRQ = 14,
  parameter int LINK_HWBRK = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_mmu,
  input  logic              req_hwbrk,
  input  logic              req_swbrk,
  input  logic              req_irq,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   msr_in,
  input  logic              dslot_in,
  input  logic              imm_in,
  input  logic [XLEN-1:0]   btgt_in,
  input  logic              bimm_in,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_idx,
  output logic [XLEN-1:0]   rf_data,
  output logic              msr_we,
  output logic [XLEN-1:0]   msr_out,
  output logic              pc_we,
  output logic [XLEN-1:0]   pc_out,
  output logic              esr_ds_set,
  output logic              btr_we,
  output logic [XLEN-1:0]   btr_out,
  output logic              flags_clr
);
  localparam int B_IE  = 1;
  localparam int B_BIP = 3;
  localparam int B_EIP = 9;
  localparam int B_UM  = 11;
  localparam int B_UMS = 12;
  localparam int B_VM  = 13;
  localparam int B_VMS = 14;
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic irq_ok, take_mmu, take_hw, take_sw, take_irq, take_any;
  logic [XLEN-1:0] msr_sv, rewind, mmu_ret;

  assign irq_ok   = req_irq & msr_in[B_IE] & ~msr_in[B_EIP] & ~msr_in[B_BIP] & ~dslot_in;
  assign take_mmu = req_mmu;
  assign take_hw  = ~req_mmu & req_hwbrk;
  assign take_sw  = ~req_mmu & ~req_hwbrk & req_swbrk;
  assign take_irq = ~req_mmu & ~req_hwbrk & ~req_swbrk & irq_ok;
  assign take_any = take_mmu | take_hw | take_sw | take_irq;

  always_comb begin
    msr_sv = msr_in;
    msr_sv[B_VMS] = msr_in[B_VM];
    msr_sv[B_UMS] = msr_in[B_UM];
    msr_sv[B_VM]  = 1'b0;
    msr_sv[B_UM]  = 1'b0;
  end

  assign rewind  = dslot_in ? (bimm_in ? STEP + STEP : STEP) : (imm_in ? STEP : '0);
  assign mmu_ret = pc_in - rewind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_we <= 1'b0; rf_idx <= '0; rf_data <= '0;
      msr_we <= 1'b0; msr_out <= '0;
      pc_we <= 1'b0; pc_out <= '0;
      esr_ds_set <= 1'b0; btr_we <= 1'b0; btr_out <= '0;
      flags_clr <= 1'b0;
    end else begin
      rf_we <= 1'b0; msr_we <= take_any; pc_we <= take_any;
      esr_ds_set <= 1'b0; btr_we <= 1'b0; flags_clr <= 1'b0;
      if (take_mmu) begin
        rf_we <= 1'b1;
        rf_idx <= RIDX_W'(LINK_MMU);
        rf_data <= mmu_ret;
        msr_out <= msr_sv | (XLEN'(1) << B_EIP);
        pc_out <= VEC_MMU;
        esr_ds_set <= dslot_in;
        btr_we <= dslot_in;
        if (dslot_in) btr_out <= btgt_in;
        flags_clr <= 1'b1;
      end else if (take_hw) begin
        rf_we <= 1'b1;
        rf_idx <= RIDX_W'(LINK_HWBRK);
        rf_data <= pc_in;
        msr_out <= msr_sv | (XLEN'(1) << B_BIP);
        pc_out <= VEC_HWBRK;
      end else if (take_sw) begin
        msr_out <= msr_sv | (XLEN'(1) << B_BIP);
        pc_out <= btgt_in;
      end else if (take_irq) begin
        rf_we <= 1'b1;
        rf_idx <= RIDX_W'(LINK_IRQ);
        rf_data <= pc_in;
        msr_out <= msr_sv & ~(XLEN'(1) << B_IE);
        pc_out <= VEC_IRQ;
      end
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32,
  parameter int RIDX_W = 5,
  parameter logic [XLEN-1:0] VEC_MMU = 'h20,
  parameter logic [XLEN-1:0] VEC_IRQ = 'h10,
  parameter logic [XLEN-1:0] VEC_HWBRK = 'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_mmu,
  input logic              req_hwbrk,
  input logic              req_swbrk,
  input logic              req_irq,
  input logic [XLEN-1:0]   pc_in,
  input logic [XLEN-1:0]   msr_in,
  input logic              dslot_in,
  input logic [XLEN-1:0]   btgt_in,
  input logic              rf_we,
  input logic [RIDX_W-1:0] rf_idx,
  input logic              msr_we,
  input logic [XLEN-1:0]   msr_out,
  input logic              pc_we,
  input logic [XLEN-1:0]   pc_out
);
  logic others;
  assign others = req_mmu | req_hwbrk | req_swbrk;

  a_r2_mmu_vector: assert property (@(posedge clk) disable iff (!rst_n)
    req_mmu |=> (pc_we && pc_out == VEC_MMU && rf_we && rf_idx == RIDX_W'(17) && msr_out[9]));

  a_r9_hwbrk_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (req_hwbrk && !req_mmu) |=> (pc_we && pc_out == VEC_HWBRK && rf_idx == RIDX_W'(16) && msr_out[3]));

  a_r10_swbrk_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (req_swbrk && !req_mmu && !req_hwbrk) |=> (pc_we && !rf_we && pc_out == $past(btgt_in)));

  a_r7_irq_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && !others && (!msr_in[1] || msr_in[9] || msr_in[3] || dslot_in)) |=> (!pc_we && !rf_we && !msr_we));

  a_r8_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && !others && msr_in[1] && !msr_in[9] && !msr_in[3] && !dslot_in)
      |=> (pc_out == VEC_IRQ && rf_idx == RIDX_W'(14) && !msr_out[1]));

  a_r6_mode_save: assert property (@(posedge clk) disable iff (!rst_n)
    (others || req_irq) && pc_we == 1'b0 ##1 pc_we
      |-> (msr_out[14] == $past(msr_in[13]) && msr_out[12] == $past(msr_in[11]) && !msr_out[13] && !msr_out[11]));

  a_r12_strobe_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || msr_we) |-> pc_we);

  a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!others && !req_irq) |=> !pc_we);
endmodule

bind exc_entry_ctrl exc_entry_chk #(
  .XLEN(XLEN), .RIDX_W(RIDX_W), .VEC_MMU(VEC_MMU), .VEC_IRQ(VEC_IRQ), .VEC_HWBRK(VEC_HWBRK)
) u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic clk = 0, rst_n = 0;
  logic req_mmu = 0, req_hwbrk = 0, req_swbrk = 0, req_irq = 0;
  logic [31:0] pc_in = 0, msr_in = 0, btgt_in = 0;
  logic dslot_in = 0, imm_in = 0, bimm_in = 0;
  logic rf_we, msr_we, pc_we, esr_ds_set, btr_we, flags_clr;
  logic [4:0] rf_idx;
  logic [31:0] rf_data, msr_out, pc_out, btr_out;

  always #5 clk = ~clk;

  exc_entry_ctrl dut (.*);

  typedef struct {
    string tag;
    logic rf_we; logic [4:0] idx; logic [31:0] rdat;
    logic pc_we; logic [31:0] pc; logic [31:0] msr;
    logic esr; logic btr_we; logic [31:0] btr; logic fclr;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [31:0] save_modes(logic [31:0] m);
    logic [31:0] r;
    r = m & ~32'h0000_7800;
    if (m[13]) r |= 32'h4000;
    if (m[11]) r |= 32'h1000;
    return r;
  endfunction

  task automatic apply(string tag, bit mm, bit hw, bit sw, bit ir,
                       logic [31:0] pc, logic [31:0] msr, bit ds, bit im,
                       logic [31:0] bt, bit bim);
    exp_t e;
    @(negedge clk);
    req_mmu = mm; req_hwbrk = hw; req_swbrk = sw; req_irq = ir;
    pc_in = pc; msr_in = msr; dslot_in = ds; imm_in = im; btgt_in = bt; bimm_in = bim;
    e = '{tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
    e.tag = tag;
    if (mm) begin
      e.rf_we = 1; e.idx = 17; e.pc_we = 1; e.pc = 32'h20; e.fclr = 1;
      e.msr = save_modes(msr) | 32'h200;
      if (ds) begin
        e.rdat = pc - (bim ? 32'd8 : 32'd4); e.esr = 1; e.btr_we = 1; e.btr = bt;
      end else e.rdat = im ? pc - 32'd4 : pc;
    end else if (hw) begin
      e.rf_we = 1; e.idx = 16; e.rdat = pc; e.pc_we = 1; e.pc = 32'h18;
      e.msr = save_modes(msr) | 32'h8;
    end else if (sw) begin
      e.pc_we = 1; e.pc = bt; e.msr = save_modes(msr) | 32'h8;
    end else if (ir && msr[1] && !msr[9] && !msr[3] && !ds) begin
      e.rf_we = 1; e.idx = 14; e.rdat = pc; e.pc_we = 1; e.pc = 32'h10;
      e.msr = save_modes(msr) & ~32'h2;
    end
    q.push_back(e);
  endtask

  always begin
    @(posedge clk); #2;
    if (q.size() > 0) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = (rf_we !== e.rf_we) || (pc_we !== e.pc_we) || (msr_we !== e.pc_we) ||
            (esr_ds_set !== e.esr) || (btr_we !== e.btr_we) || (flags_clr !== e.fclr);
      if (e.rf_we && (rf_idx !== e.idx || rf_data !== e.rdat)) bad = 1;
      if (e.pc_we && (pc_out !== e.pc || msr_out !== e.msr)) bad = 1;
      if (e.btr_we && btr_out !== e.btr) bad = 1;
      n_chk++;
      if (bad) begin
        n_fail++;
        $display("FAIL %s: got we=%b idx=%0d rd=%h pcwe=%b pc=%h msr=%h esr=%b btrwe=%b btr=%h clr=%b exp we=%b idx=%0d rd=%h pcwe=%b pc=%h msr=%h esr=%b btrwe=%b btr=%h clr=%b",
          e.tag, rf_we, rf_idx, rf_data, pc_we, pc_out, msr_out, esr_ds_set, btr_we, btr_out, flags_clr,
          e.rf_we, e.idx, e.rdat, e.pc_we, e.pc, e.msr, e.esr, e.btr_we, e.btr, e.fclr);
      end
    end
  end

  task automatic idle(string tag);
    apply(tag, 0, 0, 0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 0);
  endtask

  initial begin
    #200_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    n_chk++;
    if ({rf_we, msr_we, pc_we, esr_ds_set, btr_we, flags_clr} !== 6'b0) begin
      n_fail++;
      $display("FAIL R1: got strobes %b, expected 000000",
               {rf_we, msr_we, pc_we, esr_ds_set, btr_we, flags_clr});
    end
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    n_chk++;
    if ({rf_we, msr_we, pc_we, esr_ds_set, btr_we, flags_clr} !== 6'b0) begin
      n_fail++;
      $display("FAIL R1: got strobes %b after release, expected 000000",
               {rf_we, msr_we, pc_we, esr_ds_set, btr_we, flags_clr});
    end
    // R2/R5: plain MMU fault, no rewind
    apply("R2", 1, 0, 0, 0, 32'h0000_1000, 32'h0000_0102, 0, 0, 32'h0, 0);
    idle("R12");
    // R3: delay slot rewinds one word
    apply("R3", 1, 0, 0, 0, 32'h0000_2004, 32'h0000_2802, 1, 0, 32'h0000_3000, 0);
    // R4: delay slot after prefixed branch rewinds two words
    apply("R4", 1, 0, 0, 0, 32'h0000_2008, 32'h0000_0800, 1, 1, 32'h0000_4000, 1);
    // R5: immediate prefix only
    apply("R5", 1, 0, 0, 0, 32'h0000_500c, 32'h0000_2000, 0, 1, 32'hdead_0000, 1);
    idle("R12");
    // R6: mode patterns
    apply("R6", 0, 1, 0, 0, 32'h0000_0040, 32'h8000_2800, 0, 0, 32'h0, 0);
    apply("R6", 0, 1, 0, 0, 32'h0000_0044, 32'h0000_5000, 0, 0, 32'h0, 0);
    // R8: interrupt accepted
    apply("R8", 0, 0, 0, 1, 32'h0000_0a00, 32'h0000_2802, 0, 0, 32'h0, 0);
    // R7: refused interrupts
    apply("R7", 0, 0, 0, 1, 32'h0000_0a04, 32'h0000_0000, 0, 0, 32'h0, 0);
    apply("R7", 0, 0, 0, 1, 32'h0000_0a08, 32'h0000_0202, 0, 0, 32'h0, 0);
    apply("R7", 0, 0, 0, 1, 32'h0000_0a0c, 32'h0000_000a, 0, 0, 32'h0, 0);
    apply("R7", 0, 0, 0, 1, 32'h0000_0a10, 32'h0000_0002, 1, 0, 32'h0, 0);
    // R9: hardware break
    apply("R9", 0, 1, 0, 0, 32'h0000_0b00, 32'h0000_0002, 0, 0, 32'h0, 0);
    // R10: software break
    apply("R10", 0, 0, 1, 0, 32'h0000_0c00, 32'h0000_2002, 0, 0, 32'h0000_8000, 0);
    // R11: priority
    apply("R11", 1, 1, 1, 1, 32'h0000_0d00, 32'h0000_0002, 0, 0, 32'h0000_9000, 0);
    apply("R11", 0, 1, 1, 1, 32'h0000_0d04, 32'h0000_0002, 0, 0, 32'h0000_9000, 0);
    apply("R11", 0, 0, 1, 1, 32'h0000_0d08, 32'h0000_0002, 0, 0, 32'h0000_9100, 0);
    idle("R12");
    idle("R12");
    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule